// File: doc/BRIEF.md
# Debug Memory Access Command Handler

The handler serves debug memory reads and writes that reach it as a byte stream once an upstream parser has already recognised the command word. The upstream parser pulses `cmd_start` and gives the direction on `cmd_write`. Three unsigned LEB128 arguments then follow on the input stream, in this order: a reserved flags value, the starting byte address and the byte count. A write also carries that many data bytes after the count. The handler turns the request into accesses on a simple request/acknowledge memory bus that is one wide word across, with a byte-enable per lane.

A read answers on the output stream with the requested bytes in ascending address order, followed by one status byte. A write answers with the status byte alone. Status 0 means success, 1 means the bus flagged an error, and 2 means an argument was encoded with more bytes than its field can hold. The `single_word` input limits every bus transaction to one aligned 32-bit word, for memories that fault on wider or unaligned accesses. Otherwise each transaction covers as much of one aligned 64-bit word as the request needs.

Top module: `leb_mem_access`

## Requirements
- R1: Each argument is decoded as unsigned LEB128. Each byte carries 7 value bits, the least significant group comes first, and bit 7 set means another byte of the same argument follows. Non-minimal encodings (extra bytes with zero groups) are accepted.
- R2: A read replies with exactly count data bytes, in ascending address order, followed by one status byte. The input stream is never ready while a reply byte is offered.
- R3: A write consumes count data bytes after the count argument. Each byte lands in the bus lane selected by the low address bits. The reply is a single status byte.
- R4: With `single_word` low, every bus transaction has an address aligned to 8 bytes and a non-zero byte-enable. The enable covers only the requested bytes of that word.
- R5: With `single_word` high, every bus transaction has an address aligned to 4 bytes. Its enables lie within the one 4-byte half that the address selects.
- R6: The flags value has no effect on the accesses or on the reply.
- R7: An argument longer than its limit gives status 2, and the command then makes no bus access. The limits are 2 bytes for flags, 5 bytes for the address and 3 bytes for the count. A read still returns count zero bytes before the status, and a write still consumes its data bytes. An argument of exactly the limit length is accepted.
- R8: A bus error response gives status 1. The command makes no further bus access. The bytes of the failing word and all later read bytes are returned as zero.
- R9: A count of zero makes no bus access, and the reply is the single status byte 0.
- R10: A bus request holds its address, enables and direction until it is acknowledged. An offered reply byte holds its value until it is accepted.
- R11: After reset, no input is accepted, no reply is offered and no bus request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| single_word | input | 1 | Limit bus transactions to one aligned 32-bit word |
| cmd_start | input | 1 | Pulse that begins a command, taken while idle |
| cmd_write | input | 1 | Direction of the starting command, 1 for write |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted when both are high |
| in_data | input | 8 | Argument and write data bytes |
| out_valid | output | 1 | Reply byte present |
| out_ready | input | 1 | Reply byte taken when both are high |
| out_data | output | 8 | Reply data or status byte |
| bus_req | output | 1 | Bus transaction requested |
| bus_we | output | 1 | Transaction is a write |
| bus_addr | output | ADDR_W | Aligned byte address of the word |
| bus_be | output | BUS_BYTES | Byte lane enables |
| bus_wdata | output | 8*BUS_BYTES | Write data by lane |
| bus_ack | input | 1 | Transaction complete |
| bus_err | input | 1 | Error response, valid with bus_ack |
| bus_rdata | input | 8*BUS_BYTES | Read data, valid with bus_ack |

## Verification
Some properties are checked on every cycle. Bus requests must stay stable until acknowledged, and reply bytes must stay stable until taken. Each transaction's alignment and lane confinement must match the selected mode, no enable-less request may appear, and the handler never accepts input while it is replying. Other behaviour can only be shown by the directed scenarios, because it depends on whole commands: LEB128 value assembly, the field length limits, the data and status content of replies, the lane placement of written bytes (read back through later commands), and the suppression of accesses after a field or bus error.

// File: rtl/lma_pkg.sv
// Shared types for the debug memory access handler.
// Assumes: one command is processed at a time; status codes are fixed.
package lma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PARSE,
        S_WCOL,
        S_WREQ,
        S_RREQ,
        S_REMIT,
        S_STATUS
    } lma_state_e;

    typedef enum logic [1:0] {
        F_FLAGS,
        F_ADDR,
        F_COUNT
    } lma_field_e;

    localparam logic [7:0] ST_OK    = 8'd0;
    localparam logic [7:0] ST_BUS   = 8'd1;
    localparam logic [7:0] ST_FIELD = 8'd2;

endpackage

// File: rtl/lma_uleb_decoder.sv
// Incremental unsigned LEB128 decoder.
// Takes one byte per accepted beat and assembles 7-bit groups, lowest group
// first. On the terminating byte (bit 7 clear) it presents the value and an
// overlength flag, then clears itself for the next argument.
// Assumes: limit_i is stable for the whole argument.
module lma_uleb_decoder #(
    parameter int VAL_W = 32,
    parameter int LEN_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beat_i,
    input  logic [7:0]       byte_i,
    input  logic [LEN_W-1:0] limit_i,
    output logic             done_o,
    output logic [VAL_W-1:0] value_o,
    output logic             long_o
);

    logic [VAL_W-1:0] acc_q;
    logic [LEN_W-1:0] idx_q;
    logic             long_q;
    logic [LEN_W+2:0] shamt;
    logic             over_now;

    // Place the current group at its bit position and flag overlength.
    always_comb begin
        shamt    = (LEN_W+3)'(idx_q) * (LEN_W+3)'(7);
        value_o  = acc_q | (VAL_W'(byte_i[6:0]) << shamt);
        over_now = (idx_q >= limit_i);
        long_o   = long_q | over_now;
        done_o   = beat_i & ~byte_i[7];
    end

    // Accumulate groups; restart after the terminating byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            idx_q  <= '0;
            long_q <= 1'b0;
        end else if (beat_i) begin
            if (!byte_i[7]) begin
                acc_q  <= '0;
                idx_q  <= '0;
                long_q <= 1'b0;
            end else begin
                acc_q  <= value_o;
                long_q <= long_q | over_now;
                if (idx_q != '1) begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/lma_lane_plan.sv
// Lane planner for one bus word.
// From the current byte offset and the bytes still to move, it gives the
// enables of the chunk that starts here and says whether the current byte
// closes its chunk. A chunk ends at the lane boundary: the whole bus word
// normally, or an aligned SW_BYTES group in single-word mode.
// Assumes: BUS_BYTES and SW_BYTES are powers of two, SW_BYTES <= BUS_BYTES.
module lma_lane_plan #(
    parameter int BUS_BYTES = 8,
    parameter int SW_BYTES  = 4,
    parameter int CNT_W     = 16,
    localparam int OFF_W    = $clog2(BUS_BYTES)
) (
    input  logic [OFF_W-1:0]     off_i,
    input  logic [CNT_W-1:0]     rem_i,
    input  logic                 single_i,
    output logic [BUS_BYTES-1:0] be_o,
    output logic                 last_o
);

    logic [OFF_W-1:0] lane_end;

    // Compute the last offset of the current lane group.
    always_comb begin
        lane_end = off_i | (single_i ? OFF_W'(SW_BYTES - 1) : OFF_W'(BUS_BYTES - 1));
        last_o   = (rem_i == CNT_W'(1)) || (off_i == lane_end);
    end

    // Enable each byte from here to the group end, bounded by the remainder.
    always_comb begin
        for (int k = 0; k < BUS_BYTES; k++) begin
            be_o[k] = (OFF_W'(k) >= off_i) && (OFF_W'(k) <= lane_end) &&
                      (CNT_W'(OFF_W'(OFF_W'(k) - off_i)) < rem_i);
        end
    end

endmodule

// File: rtl/leb_mem_access.sv
// Debug memory access command handler.
// After cmd_start it decodes the flags, address and count arguments as
// LEB128 from the input stream. It then moves the data over the word bus
// one chunk at a time and replies with read data and/or a status byte.
// Assumes: single_word is stable during a command; one bus request is
// outstanding at most; bus_err and bus_rdata are valid with bus_ack.
module leb_mem_access #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int FLAG_W    = 8,
    parameter int BUS_BYTES = 8,
    parameter int SW_BYTES  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   single_word,
    input  logic                   cmd_start,
    input  logic                   cmd_write,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [7:0]             in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [7:0]             out_data,
    output logic                   bus_req,
    output logic                   bus_we,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [BUS_BYTES-1:0]   bus_be,
    output logic [8*BUS_BYTES-1:0] bus_wdata,
    input  logic                   bus_ack,
    input  logic                   bus_err,
    input  logic [8*BUS_BYTES-1:0] bus_rdata
);

    import lma_pkg::*;

    localparam int BUS_W  = 8 * BUS_BYTES;
    localparam int OFF_W  = $clog2(BUS_BYTES);
    localparam int FLAG_B = (FLAG_W + 6) / 7;
    localparam int ADDR_B = (ADDR_W + 6) / 7;
    localparam int CNT_B  = (CNT_W + 6) / 7;
    localparam int MAX_B  = (ADDR_B > CNT_B) ? ((ADDR_B > FLAG_B) ? ADDR_B : FLAG_B)
                                             : ((CNT_B > FLAG_B) ? CNT_B : FLAG_B);
    localparam int LEN_W  = $clog2(MAX_B + 2);
    localparam int VAL_W  = (ADDR_W > CNT_W) ? ((ADDR_W > FLAG_W) ? ADDR_W : FLAG_W)
                                             : ((CNT_W > FLAG_W) ? CNT_W : FLAG_W);

    lma_state_e           state_q;
    lma_field_e           field_q;
    logic                 is_wr_q;
    logic [7:0]           status_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [CNT_W-1:0]     rem_q;
    logic [ADDR_W-1:0]    waddr_q;
    logic [BUS_W-1:0]     wbuf_q;
    logic [BUS_BYTES-1:0] wbe_q;
    logic [BUS_W-1:0]     rbuf_q;

    logic                 dec_beat;
    logic                 dec_done;
    logic                 dec_long;
    logic [VAL_W-1:0]     dec_val;
    logic [LEN_W-1:0]     dec_limit;
    logic [BUS_BYTES-1:0] plan_be;
    logic                 plan_last;
    logic [ADDR_W-1:0]    word_addr;
    logic                 access_ok;

    // Select the length limit of the argument being decoded.
    always_comb begin
        case (field_q)
            F_FLAGS: dec_limit = LEN_W'(FLAG_B);
            F_ADDR:  dec_limit = LEN_W'(ADDR_B);
            default: dec_limit = LEN_W'(CNT_B);
        endcase
    end

    assign dec_beat = (state_q == S_PARSE) && in_valid;

    lma_uleb_decoder #(
        .VAL_W (VAL_W),
        .LEN_W (LEN_W)
    ) i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .beat_i  (dec_beat),
        .byte_i  (in_data),
        .limit_i (dec_limit),
        .done_o  (dec_done),
        .value_o (dec_val),
        .long_o  (dec_long)
    );

    lma_lane_plan #(
        .BUS_BYTES (BUS_BYTES),
        .SW_BYTES  (SW_BYTES),
        .CNT_W     (CNT_W)
    ) i_plan (
        .off_i    (addr_q[OFF_W-1:0]),
        .rem_i    (rem_q),
        .single_i (single_word),
        .be_o     (plan_be),
        .last_o   (plan_last)
    );

    // Align the current address to the transaction size of the mode.
    always_comb begin
        word_addr = addr_q & ~(single_word ? ADDR_W'(SW_BYTES - 1) : ADDR_W'(BUS_BYTES - 1));
        access_ok = (status_q == ST_OK);
    end

    // Drive the stream handshakes and the bus request from the state.
    always_comb begin
        in_ready  = (state_q == S_PARSE) || (state_q == S_WCOL);
        out_valid = (state_q == S_REMIT) || (state_q == S_STATUS);
        out_data  = (state_q == S_STATUS) ? status_q
                                          : rbuf_q[{addr_q[OFF_W-1:0], 3'b000} +: 8];
        bus_we    = (state_q == S_WREQ);
        bus_req   = (state_q == S_WREQ) || ((state_q == S_RREQ) && access_ok);
        bus_addr  = (state_q == S_WREQ) ? waddr_q : word_addr;
        bus_be    = (state_q == S_WREQ) ? wbe_q : plan_be;
        bus_wdata = wbuf_q;
    end

    // Command sequencing: parse arguments, move chunks, send the reply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            field_q  <= F_FLAGS;
            is_wr_q  <= 1'b0;
            status_q <= ST_OK;
            addr_q   <= '0;
            rem_q    <= '0;
            waddr_q  <= '0;
            wbuf_q   <= '0;
            wbe_q    <= '0;
            rbuf_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (cmd_start) begin
                        is_wr_q  <= cmd_write;
                        status_q <= ST_OK;
                        field_q  <= F_FLAGS;
                        wbe_q    <= '0;
                        state_q  <= S_PARSE;
                    end
                end
                S_PARSE: begin
                    if (dec_done) begin
                        if (dec_long) begin
                            status_q <= ST_FIELD;
                        end
                        case (field_q)
                            F_FLAGS: field_q <= F_ADDR;
                            F_ADDR: begin
                                addr_q  <= dec_val[ADDR_W-1:0];
                                field_q <= F_COUNT;
                            end
                            default: begin
                                rem_q   <= dec_val[CNT_W-1:0];
                                field_q <= F_FLAGS;
                                if (dec_val[CNT_W-1:0] == '0) begin
                                    state_q <= S_STATUS;
                                end else if (is_wr_q) begin
                                    state_q <= S_WCOL;
                                end else begin
                                    state_q <= S_RREQ;
                                end
                            end
                        endcase
                    end
                end
                S_WCOL: begin
                    if (in_valid) begin
                        wbuf_q[{addr_q[OFF_W-1:0], 3'b000} +: 8] <= in_data;
                        wbe_q[addr_q[OFF_W-1:0]] <= 1'b1;
                        waddr_q <= word_addr;
                        addr_q  <= addr_q + 1'b1;
                        rem_q   <= rem_q - 1'b1;
                        if (plan_last) begin
                            if (access_ok) begin
                                state_q <= S_WREQ;
                            end else begin
                                wbe_q <= '0;
                                if (rem_q == CNT_W'(1)) begin
                                    state_q <= S_STATUS;
                                end
                            end
                        end
                    end
                end
                S_WREQ: begin
                    if (bus_ack) begin
                        wbe_q <= '0;
                        if (bus_err) begin
                            status_q <= ST_BUS;
                        end
                        state_q <= (rem_q == '0) ? S_STATUS : S_WCOL;
                    end
                end
                S_RREQ: begin
                    if (!access_ok) begin
                        rbuf_q  <= '0;
                        state_q <= S_REMIT;
                    end else if (bus_ack) begin
                        if (bus_err) begin
                            status_q <= ST_BUS;
                            rbuf_q   <= '0;
                        end else begin
                            rbuf_q <= bus_rdata;
                        end
                        state_q <= S_REMIT;
                    end
                end
                S_REMIT: begin
                    if (out_ready) begin
                        addr_q <= addr_q + 1'b1;
                        rem_q  <= rem_q - 1'b1;
                        if (rem_q == CNT_W'(1)) begin
                            state_q <= S_STATUS;
                        end else if (plan_last) begin
                            state_q <= S_RREQ;
                        end
                    end
                end
                S_STATUS: begin
                    if (out_ready) begin
                        state_q <= S_IDLE;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lma_checker.sv
// Protocol checker for leb_mem_access, attached by bind.
// Watches only the ports: bus stability, stream stability, lane rules.
module lma_checker #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 8,
    parameter int SW_BYTES  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 single_word,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic [7:0]           out_data,
    input logic                 bus_req,
    input logic                 bus_we,
    input logic                 bus_ack,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [BUS_BYTES-1:0] bus_be
);

    localparam int OFF_W = $clog2(BUS_BYTES);

    logic [BUS_BYTES-1:0] half_mask;

    // Lanes that belong to the 32-bit group the address selects.
    always_comb begin
        for (int k = 0; k < BUS_BYTES; k++) begin
            half_mask[k] = ((k / SW_BYTES) == (int'(bus_addr[OFF_W-1:0]) / SW_BYTES));
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_be) && $stable(bus_we)) // R10
        else $error("bus request changed before acknowledge");

    AST_REPLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)) // R10
        else $error("reply byte changed before acceptance");

    AST_WIDE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !single_word |-> (bus_addr & ADDR_W'(BUS_BYTES - 1)) == '0) // R4
        else $error("wide transaction not aligned");

    AST_BE_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> bus_be != '0) // R4
        else $error("bus request without enables");

    AST_NARROW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && single_word |-> ((bus_addr & ADDR_W'(SW_BYTES - 1)) == '0) &&
                                   ((bus_be & ~half_mask) == '0)) // R5
        else $error("single-word transaction outside its word");

    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid)) // R2
        else $error("input accepted while replying");

endmodule

bind leb_mem_access lma_checker #(
    .ADDR_W    (ADDR_W),
    .BUS_BYTES (BUS_BYTES),
    .SW_BYTES  (SW_BYTES)
) i_lma_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .single_word (single_word),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_ack     (bus_ack),
    .bus_addr    (bus_addr),
    .bus_be      (bus_be)
);

// File: tb/test_leb_mem_access.sv
// Directed bench: one task per scenario, each checking its own results.
module test_leb_mem_access;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        single_word = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_write = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        bus_req;
    logic        bus_we;
    logic [31:0] bus_addr;
    logic [7:0]  bus_be;
    logic [63:0] bus_wdata;
    logic        bus_ack;
    logic        bus_err;
    logic [63:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;

    logic [7:0]  cmd_q[$];
    logic [7:0]  rep_q[$];
    logic [7:0]  exp_q[$];
    logic [7:0]  mem_b[128];
    logic [7:0]  exp_b[128];
    logic [31:0] log_addr[64];
    logic [7:0]  log_be[64];
    logic        log_we[64];
    logic [63:0] log_wd[64];
    int          n_acc;
    int          lat = 0;
    int          wait_cnt;
    logic [31:0] err_addr = 32'hFFFF_FFFF;

    always #(CLK_PERIOD/2) clk = ~clk;

    leb_mem_access i_leb_mem_access (
        .clk, .rst_n, .single_word, .cmd_start, .cmd_write,
        .in_valid, .in_ready, .in_data,
        .out_valid, .out_ready, .out_data,
        .bus_req, .bus_we, .bus_addr, .bus_be, .bus_wdata,
        .bus_ack, .bus_err, .bus_rdata
    );

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    // Bus model: byte memory aliased on 128 bytes, programmable latency and error word.
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_ack  <= 1'b0;
            bus_err  <= 1'b0;
            n_acc    <= 0;
            wait_cnt <= 0;
            for (int a = 0; a < 128; a++) mem_b[a] <= pat(a);
        end else begin
            bus_ack <= 1'b0;
            bus_err <= 1'b0;
            if (bus_req && !bus_ack) begin
                if (wait_cnt < lat) begin
                    wait_cnt <= wait_cnt + 1;
                end else begin
                    wait_cnt <= 0;
                    bus_ack  <= 1'b1;
                    log_addr[n_acc % 64] <= bus_addr;
                    log_be[n_acc % 64]   <= bus_be;
                    log_we[n_acc % 64]   <= bus_we;
                    log_wd[n_acc % 64]   <= bus_wdata;
                    n_acc <= n_acc + 1;
                    if (bus_addr == err_addr) begin
                        bus_err <= 1'b1;
                    end else begin
                        for (int k = 0; k < 8; k++) begin
                            if (bus_we && bus_be[k])
                                mem_b[{bus_addr[6:3], 3'(k)}] <= bus_wdata[8*k +: 8];
                            bus_rdata[8*k +: 8] <= mem_b[{bus_addr[6:3], 3'(k)}];
                        end
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_uleb(input longint unsigned v);
        logic [7:0] b;
        do begin
            b = 8'(v & 64'h7F);
            v = v >> 7;
            if (v != 0) b[7] = 1'b1;
            cmd_q.push_back(b);
        end while (v != 0);
    endtask

    // Issue one command from cmd_q and collect nrep reply bytes into rep_q.
    task automatic run_cmd(input bit wr, input int nrep);
        rep_q.delete();
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_write = wr;
        @(negedge clk);
        cmd_start = 1'b0;
        foreach (cmd_q[i]) begin
            in_valid = 1'b1;
            in_data  = cmd_q[i];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        cmd_q.delete();
        out_ready = 1'b1;
        for (int i = 0; i < nrep; i++) begin
            while (!out_valid) @(negedge clk);
            rep_q.push_back(out_data);
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
    endtask

    task automatic chk_reply(input string req);
        chk({req, " reply length"}, 64'(rep_q.size()), 64'(exp_q.size()));
        foreach (exp_q[i]) begin
            if (i < rep_q.size()) chk({req, " reply byte"}, 64'(rep_q[i]), 64'(exp_q[i]));
        end
        repeat (3) @(negedge clk);
        chk({req, " no extra reply"}, 64'(out_valid), 64'd0);
        exp_q.delete();
    endtask

    task automatic chk_acc(input string req, input int idx, input logic [31:0] a,
                           input logic [7:0] be, input logic we);
        chk({req, " bus addr"}, 64'(log_addr[idx]), 64'(a));
        chk({req, " bus be"}, 64'(log_be[idx]), 64'(be));
        chk({req, " bus we"}, 64'(log_we[idx]), 64'(we));
    endtask

    task automatic exp_read(input int a, input int n, input logic [7:0] st);
        for (int i = 0; i < n; i++) exp_q.push_back(exp_b[(a + i) % 128]);
        exp_q.push_back(st);
    endtask

    task automatic t_reset;
        chk("R11 in_ready", 64'(in_ready), 64'd0);
        chk("R11 out_valid", 64'(out_valid), 64'd0);
        chk("R11 bus_req", 64'(bus_req), 64'd0);
    endtask

    task automatic t_read_basic;
        int base = n_acc;
        put_uleb(0); put_uleb(5); put_uleb(6);
        run_cmd(1'b0, 7);
        exp_read(5, 6, 8'd0);
        chk_reply("R2 read 5..10");
        chk("R4 access count", 64'(n_acc - base), 64'd2);
        chk_acc("R4 first word", base, 32'd0, 8'hE0, 1'b0);
        chk_acc("R4 second word", base + 1, 32'd8, 8'h07, 1'b0);
    endtask

    task automatic t_leb;
        int base = n_acc;
        cmd_q.push_back(8'h00);
        cmd_q.push_back(8'h83); cmd_q.push_back(8'h80); cmd_q.push_back(8'h01);
        cmd_q.push_back(8'h82); cmd_q.push_back(8'h00);
        run_cmd(1'b0, 3);
        exp_read(3, 2, 8'd0);
        chk_reply("R1 multi-byte fields");
        chk_acc("R1 decoded address", base, 32'h4000, 8'h18, 1'b0);
    endtask

    task automatic t_flags;
        cmd_q.push_back(8'h7F); put_uleb(16); put_uleb(2);
        run_cmd(1'b0, 3);
        exp_read(16, 2, 8'd0);
        chk_reply("R6 flags 7F");
        cmd_q.push_back(8'h85); cmd_q.push_back(8'h01); put_uleb(16); put_uleb(2);
        run_cmd(1'b0, 3);
        exp_read(16, 2, 8'd0);
        chk_reply("R6 flags two-byte");
    endtask

    task automatic t_write;
        int base = n_acc;
        put_uleb(0); put_uleb(13); put_uleb(5);
        for (int i = 0; i < 5; i++) cmd_q.push_back(8'hA0 + 8'(i));
        run_cmd(1'b1, 1);
        exp_q.push_back(8'd0);
        chk_reply("R3 write status");
        chk("R3 access count", 64'(n_acc - base), 64'd2);
        chk_acc("R3 first word", base, 32'd8, 8'hE0, 1'b1);
        chk("R3 lanes 5..7", 64'(log_wd[base][63:40]), 64'hA2A1A0);
        chk_acc("R3 second word", base + 1, 32'd16, 8'h03, 1'b1);
        chk("R3 lanes 0..1", 64'(log_wd[base + 1][15:0]), 64'hA4A3);
        for (int i = 0; i < 5; i++) exp_b[13 + i] = 8'hA0 + 8'(i);
        put_uleb(0); put_uleb(12); put_uleb(7);
        run_cmd(1'b0, 8);
        exp_read(12, 7, 8'd0);
        chk_reply("R3 readback");
    endtask

    task automatic t_single;
        int base = n_acc;
        single_word = 1'b1;
        put_uleb(0); put_uleb(6); put_uleb(4);
        run_cmd(1'b0, 5);
        exp_read(6, 4, 8'd0);
        chk_reply("R5 single read");
        chk_acc("R5 upper half", base, 32'd4, 8'hC0, 1'b0);
        chk_acc("R5 next word", base + 1, 32'd8, 8'h03, 1'b0);
        base = n_acc;
        put_uleb(0); put_uleb(2); put_uleb(3);
        cmd_q.push_back(8'h55); cmd_q.push_back(8'h66); cmd_q.push_back(8'h77);
        run_cmd(1'b1, 1);
        exp_q.push_back(8'd0);
        chk_reply("R5 single write");
        chk_acc("R5 write low half", base, 32'd0, 8'h0C, 1'b1);
        chk_acc("R5 write high half", base + 1, 32'd4, 8'h10, 1'b1);
        exp_b[2] = 8'h55; exp_b[3] = 8'h66; exp_b[4] = 8'h77;
        put_uleb(0); put_uleb(0); put_uleb(8);
        run_cmd(1'b0, 9);
        exp_read(0, 8, 8'd0);
        chk_reply("R5 single readback");
        single_word = 1'b0;
    endtask

    task automatic t_zero;
        int base = n_acc;
        put_uleb(0); put_uleb(40); put_uleb(0);
        run_cmd(1'b0, 1);
        exp_q.push_back(8'd0);
        chk_reply("R9 zero read");
        put_uleb(0); put_uleb(40); put_uleb(0);
        run_cmd(1'b1, 1);
        exp_q.push_back(8'd0);
        chk_reply("R9 zero write");
        chk("R9 no access", 64'(n_acc - base), 64'd0);
    endtask

    task automatic t_overlong;
        int base = n_acc;
        put_uleb(0);
        repeat (5) cmd_q.push_back(8'h80);
        cmd_q.push_back(8'h00);
        put_uleb(3);
        run_cmd(1'b0, 4);
        exp_q = '{8'd0, 8'd0, 8'd0, 8'd2};
        chk_reply("R7 six-byte address");
        cmd_q = '{8'h80, 8'h80, 8'h00, 8'h00, 8'h01};
        run_cmd(1'b0, 2);
        exp_q = '{8'd0, 8'd2};
        chk_reply("R7 three-byte flags");
        cmd_q = '{8'h00, 8'h04, 8'h83, 8'h80, 8'h80, 8'h00, 8'h11, 8'h22, 8'h33};
        run_cmd(1'b1, 1);
        exp_q.push_back(8'd2);
        chk_reply("R7 four-byte count write");
        chk("R7 no access", 64'(n_acc - base), 64'd0);
        cmd_q = '{8'h00, 8'h80, 8'h80, 8'h80, 8'h80, 8'h00, 8'h01};
        run_cmd(1'b0, 2);
        exp_read(0, 1, 8'd0);
        chk_reply("R7 five-byte address accepted");
        put_uleb(0); put_uleb(4); put_uleb(3);
        run_cmd(1'b0, 4);
        exp_read(4, 3, 8'd0);
        chk_reply("R7 memory untouched");
    endtask

    task automatic t_buserr;
        int base = n_acc;
        err_addr = 32'd8;
        put_uleb(0); put_uleb(4); put_uleb(14);
        run_cmd(1'b0, 15);
        for (int i = 0; i < 4; i++) exp_q.push_back(exp_b[4 + i]);
        repeat (10) exp_q.push_back(8'd0);
        exp_q.push_back(8'd1);
        chk_reply("R8 read error");
        chk("R8 read stops", 64'(n_acc - base), 64'd2);
        base = n_acc;
        put_uleb(0); put_uleb(6); put_uleb(4);
        cmd_q.push_back(8'hC1); cmd_q.push_back(8'hC2);
        cmd_q.push_back(8'hC3); cmd_q.push_back(8'hC4);
        run_cmd(1'b1, 1);
        exp_q.push_back(8'd1);
        chk_reply("R8 write error");
        chk("R8 write accesses", 64'(n_acc - base), 64'd2);
        exp_b[6] = 8'hC1; exp_b[7] = 8'hC2;
        err_addr = 32'hFFFF_FFFF;
        put_uleb(0); put_uleb(6); put_uleb(4);
        run_cmd(1'b0, 5);
        exp_read(6, 4, 8'd0);
        chk_reply("R8 write readback");
    endtask

    task automatic t_stall;
        logic [7:0] held;
        lat = 3;
        put_uleb(0); put_uleb(20); put_uleb(3);
        @(negedge clk);
        cmd_start = 1'b1;
        cmd_write = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        foreach (cmd_q[i]) begin
            in_valid = 1'b1;
            in_data  = cmd_q[i];
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
        end
        in_valid = 1'b0;
        cmd_q.delete();
        while (!out_valid) @(negedge clk);
        held = out_data;
        repeat (3) @(negedge clk);
        chk("R10 valid held", 64'(out_valid), 64'd1);
        chk("R10 data held", 64'(out_data), 64'(held));
        chk("R10 first byte", 64'(held), 64'(exp_b[20]));
        out_ready = 1'b1;
        rep_q.delete();
        for (int i = 0; i < 4; i++) begin
            while (!out_valid) @(negedge clk);
            rep_q.push_back(out_data);
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        exp_read(20, 3, 8'd0);
        chk_reply("R10 slow bus read");
        lat = 0;
    endtask

    task automatic finish_up;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        for (int a = 0; a < 128; a++) exp_b[a] = pat(a);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_basic();
        t_leb();
        t_flags();
        t_write();
        t_single();
        t_zero();
        t_overlong();
        t_buserr();
        t_stall();
        finish_up();
    end

endmodule